// File: doc/BRIEF.md
# Transmit Descriptor Ring Manager

This block owns a circular ring of transmit descriptors held in internal registers and tracks which side owns each entry. The host side queues a frame by presenting its length for one cycle. If the block accepts it, the block writes a send control word into the slot under the insert pointer, hands that slot to the device, and raises a poll strobe toward the device side on the next cycle. Frame contents are out of scope. The slot index stands in for the frame buffer.

A device-side model scans the ring through a combinational read port. It finishes a descriptor by writing a status word whose top bit is clear. The block reclaims finished descriptors strictly in ring order, one per cycle, and stops at the first descriptor the device still owns. Completion status is screened for transmit errors. An underrun report turns on store-and-forward mode, which stays on until reset.

Top module: `tx_ring_mgr`

## Requirements
- R1: A synchronous reset clears both pointers, the outstanding count, store-and-forward mode and the poll strobe. It sets every status word to 0 and every control word to 0x81000000.
- R2: A submit is accepted when its length is at most 1514 and fewer than 14 frames are outstanding. `sub_ack` is high in the same cycle. From the next cycle, the slot under the insert pointer holds control 0xE1000000 ORed with the length and status 0x80000000, the insert pointer has advanced by one and the count has risen by one.
- R3: A submit longer than 1514 bytes is refused with `sub_nak`. No slot, pointer or count changes.
- R4: A submit made while 14 frames are outstanding is refused with `sub_nak`, and the count never exceeds 14.
- R5: `tx_poll` is high in the cycle after an accepted submit and low after a cycle with no accepted submit.
- R6: A device status write takes effect only when the target descriptor's bit 31 (ownership) is set. A write to a host-owned descriptor is ignored.
- R7: While the count is non-zero and bit 31 of the status under the remove pointer is clear, `rcl_fire` is high. On the next edge the remove pointer advances by one and the count drops by one. A descriptor still owned by the device blocks the reclaim of every descriptor after it.
- R8: A reclaimed status that has any bit of mask 0x4302 set flags `rcl_err`. If its bit 1 (underrun) is set, store-and-forward mode turns on from the next cycle and stays on until reset.
- R9: A reclaimed status of exactly 0x7FFFFFFF is a clean completion. It raises no error and does not change store-and-forward mode.
- R10: The link output of each descriptor names the next index, and the last descriptor links to index 0.
- R11: Both pointers wrap modulo 16, and the count always equals the insert pointer minus the remove pointer, modulo 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sub_valid | input | 1 | Host submit request, one cycle per frame |
| sub_len | input | 14 | Frame length in bytes |
| sub_ack | output | 1 | Submit accepted (same cycle) |
| sub_nak | output | 1 | Submit refused (same cycle) |
| tx_poll | output | 1 | Poll strobe toward the device side |
| dev_we | input | 1 | Device status write enable |
| dev_widx | input | 4 | Descriptor index for the status write |
| dev_wdata | input | 32 | Status word written by the device |
| rd_idx | input | 4 | Descriptor index for the read port |
| rd_status | output | 32 | Status word of the selected descriptor |
| rd_ctrl | output | 32 | Control word of the selected descriptor |
| rd_link | output | 4 | Index of the next descriptor in the chain |
| ins_ptr | output | 4 | Insert pointer |
| rm_ptr | output | 4 | Remove pointer |
| pending | output | 5 | Outstanding frame count |
| sf_mode | output | 1 | Store-and-forward mode |
| rcl_fire | output | 1 | A descriptor is reclaimed at the coming edge |
| rcl_err | output | 1 | The descriptor being reclaimed reports a transmit error |

## Verification
`sub_ack`, `sub_nak`, `rcl_fire`, `rcl_err` and the read port are combinational, so the bench samples them one time step after it drives its inputs, in the same cycle. Slot contents, pointers, the count and `tx_poll` change on the next edge, and store-and-forward mode changes on the edge after a faulty completion is written. The bench checks these only after that edge. A device write lands on one edge and its reclaim on the following edge, so each check of the remove pointer comes two edges after the write that frees the slot.

// File: rtl/tx_ring_mgr.sv
module tx_ring_mgr #(
  parameter int DEPTH   = 16,
  parameter int LIMIT   = DEPTH - 2,
  parameter int MAX_LEN = 1514,
  parameter int LEN_W   = 14
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     sub_valid,
  input  logic [LEN_W-1:0]         sub_len,
  output logic                     sub_ack,
  output logic                     sub_nak,
  output logic                     tx_poll,
  input  logic                     dev_we,
  input  logic [$clog2(DEPTH)-1:0] dev_widx,
  input  logic [31:0]              dev_wdata,
  input  logic [$clog2(DEPTH)-1:0] rd_idx,
  output logic [31:0]              rd_status,
  output logic [31:0]              rd_ctrl,
  output logic [$clog2(DEPTH)-1:0] rd_link,
  output logic [$clog2(DEPTH)-1:0] ins_ptr,
  output logic [$clog2(DEPTH)-1:0] rm_ptr,
  output logic [$clog2(DEPTH):0]   pending,
  output logic                     sf_mode,
  output logic                     rcl_fire,
  output logic                     rcl_err
);
  localparam int PW = $clog2(DEPTH);
  localparam logic [31:0] CTRL_IDLE = 32'h8100_0000;
  localparam logic [31:0] CTRL_SEND = 32'hE100_0000;
  localparam logic [31:0] ST_GIVE   = 32'h8000_0000;
  localparam logic [31:0] ST_DUMMY  = 32'h7FFF_FFFF;
  localparam logic [31:0] ERR_MASK  = 32'h0000_4302;
  localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(MAX_LEN);
  localparam logic [PW:0]      CAP     = (PW+1)'(LIMIT);
  localparam logic [PW-1:0]    LAST    = PW'(DEPTH - 1);

  logic [31:0] status [DEPTH];
  logic [31:0] ctrl   [DEPTH];
  logic [31:0] head;
  logic        underrun;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  assign sub_ack   = sub_valid && (sub_len <= LEN_MAX) && (pending < CAP);
  assign sub_nak   = sub_valid && !sub_ack;
  assign rd_status = status[rd_idx];
  assign rd_ctrl   = ctrl[rd_idx];
  assign rd_link   = nxt(rd_idx);
  assign head      = status[rm_ptr];
  assign rcl_fire  = (pending != '0) && !head[31];
  assign rcl_err   = rcl_fire && (head != ST_DUMMY) && |(head & ERR_MASK);
  assign underrun  = rcl_err && head[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) begin
        status[i] <= '0;
        ctrl[i]   <= CTRL_IDLE;
      end
      ins_ptr <= '0;
      rm_ptr  <= '0;
      pending <= '0;
      sf_mode <= 1'b0;
      tx_poll <= 1'b0;
    end else begin
      tx_poll <= sub_ack;
      if (dev_we && status[dev_widx][31])
        status[dev_widx] <= dev_wdata;
      if (sub_ack) begin
        status[ins_ptr] <= ST_GIVE;
        ctrl[ins_ptr]   <= CTRL_SEND | {{(32-LEN_W){1'b0}}, sub_len};
        ins_ptr         <= nxt(ins_ptr);
      end
      if (rcl_fire)
        rm_ptr <= nxt(rm_ptr);
      pending <= pending + (PW+1)'(sub_ack) - (PW+1)'(rcl_fire);
      if (underrun)
        sf_mode <= 1'b1;
    end
  end
endmodule

module tx_ring_mgr_chk #(
  parameter int DEPTH   = 16,
  parameter int LIMIT   = DEPTH - 2,
  parameter int MAX_LEN = 1514,
  parameter int LEN_W   = 14
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     sub_valid,
  input logic [LEN_W-1:0]         sub_len,
  input logic                     sub_ack,
  input logic                     tx_poll,
  input logic [$clog2(DEPTH)-1:0] ins_ptr,
  input logic [$clog2(DEPTH)-1:0] rm_ptr,
  input logic [$clog2(DEPTH):0]   pending,
  input logic                     sf_mode,
  input logic                     rcl_fire
);
  assert_cap_R4: assert property (@(posedge clk) disable iff (rst)
    int'(pending) <= LIMIT);
  assert_poll_R5: assert property (@(posedge clk) disable iff (rst)
    sub_ack |=> tx_poll);
  assert_nopoll_R5: assert property (@(posedge clk) disable iff (rst)
    !sub_ack |=> !tx_poll);
  assert_oversize_R3: assert property (@(posedge clk) disable iff (rst)
    (sub_valid && int'(sub_len) > MAX_LEN) |=> $stable(ins_ptr));
  assert_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    sf_mode |=> sf_mode);
  assert_advance_R7: assert property (@(posedge clk) disable iff (rst)
    rcl_fire |=> rm_ptr != $past(rm_ptr));
  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !rcl_fire |=> $stable(rm_ptr));
  assert_empty_R7: assert property (@(posedge clk) disable iff (rst)
    (pending == '0) |-> !rcl_fire);
  assert_occupancy_R11: assert property (@(posedge clk) disable iff (rst)
    int'(pending) == ((int'(ins_ptr) + DEPTH - int'(rm_ptr)) % DEPTH));
endmodule

bind tx_ring_mgr tx_ring_mgr_chk #(
  .DEPTH(DEPTH), .LIMIT(LIMIT), .MAX_LEN(MAX_LEN), .LEN_W(LEN_W)
) u_chk (
  .clk(clk), .rst(rst), .sub_valid(sub_valid), .sub_len(sub_len),
  .sub_ack(sub_ack), .tx_poll(tx_poll), .ins_ptr(ins_ptr), .rm_ptr(rm_ptr),
  .pending(pending), .sf_mode(sf_mode), .rcl_fire(rcl_fire)
);

// File: tb/tb_tx_ring_mgr.sv
module tb_tx_ring_mgr;
  logic        clk = 1'b0;
  logic        rst;
  logic        sub_valid;
  logic [13:0] sub_len;
  logic        sub_ack, sub_nak, tx_poll;
  logic        dev_we;
  logic [3:0]  dev_widx;
  logic [31:0] dev_wdata;
  logic [3:0]  rd_idx;
  logic [31:0] rd_status, rd_ctrl;
  logic [3:0]  rd_link, ins_ptr, rm_ptr;
  logic [4:0]  pending;
  logic        sf_mode, rcl_fire, rcl_err;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  tx_ring_mgr dut (
    .clk(clk), .rst(rst), .sub_valid(sub_valid), .sub_len(sub_len),
    .sub_ack(sub_ack), .sub_nak(sub_nak), .tx_poll(tx_poll),
    .dev_we(dev_we), .dev_widx(dev_widx), .dev_wdata(dev_wdata),
    .rd_idx(rd_idx), .rd_status(rd_status), .rd_ctrl(rd_ctrl),
    .rd_link(rd_link), .ins_ptr(ins_ptr), .rm_ptr(rm_ptr),
    .pending(pending), .sf_mode(sf_mode), .rcl_fire(rcl_fire),
    .rcl_err(rcl_err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic submit(input int len, input logic ok, input string req);
    sub_valid = 1'b1;
    sub_len   = 14'(len);
    #1;
    chk(req, 32'(sub_ack), 32'(ok));
    chk(req, 32'(sub_nak), 32'(!ok));
    tick();
    chk("R5", 32'(tx_poll), 32'(ok));
    sub_valid = 1'b0;
  endtask

  task automatic dev_write(input int idx, input logic [31:0] data);
    dev_we    = 1'b1;
    dev_widx  = 4'(idx);
    dev_wdata = data;
    tick();
    dev_we    = 1'b0;
  endtask

  task automatic peek(input int idx);
    rd_idx = 4'(idx);
    #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    int lens[14];
    rst = 1'b1; sub_valid = 1'b0; sub_len = '0;
    dev_we = 1'b0; dev_widx = '0; dev_wdata = '0; rd_idx = '0;
    repeat (3) tick();
    rst = 1'b0;
    #1;
    // R1 reset state, R10 chain links
    chk("R1", 32'(ins_ptr), 0);
    chk("R1", 32'(rm_ptr), 0);
    chk("R1", 32'(pending), 0);
    chk("R1", 32'(sf_mode), 0);
    chk("R1", 32'(tx_poll), 0);
    for (int i = 0; i < 16; i++) begin
      peek(i);
      chk("R1", rd_status, 32'h0);
      chk("R1", rd_ctrl, 32'h8100_0000);
      chk("R10", 32'(rd_link), 32'((i + 1) % 16));
    end

    // R3 oversize refused
    submit(1515, 1'b0, "R3");
    chk("R3", 32'(pending), 0);
    chk("R3", 32'(ins_ptr), 0);
    peek(0);
    chk("R3", rd_ctrl, 32'h8100_0000);
    chk("R3", rd_status, 32'h0);

    // R2 fill to the occupancy limit, last frame at the size boundary
    for (int i = 0; i < 14; i++) begin
      lens[i] = (i == 13) ? 1514 : 64 + i * 97;
      submit(lens[i], 1'b1, "R2");
      peek(i);
      chk("R2", rd_ctrl, 32'hE100_0000 | 32'(lens[i]));
      chk("R2", rd_status, 32'h8000_0000);
      chk("R2", 32'(pending), 32'(i + 1));
      chk("R2", 32'(ins_ptr), 32'((i + 1) % 16));
    end

    // R4 full ring refuses
    submit(100, 1'b0, "R4");
    chk("R4", 32'(pending), 14);
    chk("R4", 32'(ins_ptr), 14);
    peek(14);
    chk("R4", rd_ctrl, 32'h8100_0000);

    // R6 write to host-owned slot ignored
    dev_write(14, 32'h0000_1234);
    peek(14);
    chk("R6", rd_status, 32'h0);

    // R7 out-of-order completion blocked by owned head
    dev_write(2, 32'h0);
    peek(2);
    chk("R6", rd_status, 32'h0);
    chk("R7", 32'(rcl_fire), 0);
    tick();
    chk("R7", 32'(rm_ptr), 0);
    chk("R7", 32'(pending), 14);

    dev_write(0, 32'h0);
    chk("R7", 32'(rcl_fire), 1);
    tick();
    chk("R7", 32'(rm_ptr), 1);
    chk("R7", 32'(pending), 13);
    chk("R7", 32'(rcl_fire), 0);

    dev_write(1, 32'h0);
    chk("R7", 32'(rcl_fire), 1);
    tick();
    chk("R7", 32'(rm_ptr), 2);
    chk("R7", 32'(rcl_fire), 1);
    tick();
    chk("R7", 32'(rm_ptr), 3);
    chk("R7", 32'(pending), 11);
    chk("R7", 32'(rcl_fire), 0);

    // R9 dummy completion is clean
    dev_write(3, 32'h7FFF_FFFF);
    chk("R9", 32'(rcl_fire), 1);
    chk("R9", 32'(rcl_err), 0);
    tick();
    chk("R9", 32'(sf_mode), 0);
    chk("R9", 32'(rm_ptr), 4);

    // R8 underrun enables store-and-forward
    dev_write(4, 32'h0000_0002);
    chk("R8", 32'(rcl_err), 1);
    chk("R8", 32'(sf_mode), 0);
    tick();
    chk("R8", 32'(sf_mode), 1);

    dev_write(5, 32'h0000_4000);
    chk("R8", 32'(rcl_err), 1);
    tick();
    chk("R8", 32'(sf_mode), 1);
    chk("R8", 32'(rm_ptr), 6);

    for (int i = 6; i < 14; i++) dev_write(i, 32'h0);
    tick();
    tick();
    chk("R7", 32'(rm_ptr), 14);
    chk("R7", 32'(pending), 0);
    chk("R7", 32'(rcl_fire), 0);
    chk("R8", 32'(sf_mode), 1);

    // R11 wrap of both pointers
    for (int i = 0; i < 4; i++) submit(200 + i, 1'b1, "R11");
    chk("R11", 32'(ins_ptr), 2);
    chk("R11", 32'(pending), 4);
    peek(0);
    chk("R11", rd_ctrl, 32'hE100_0000 | 32'd202);
    peek(15);
    chk("R10", 32'(rd_link), 0);
    dev_write(14, 32'h0);
    dev_write(15, 32'h0);
    dev_write(0, 32'h0);
    dev_write(1, 32'h0);
    tick();
    tick();
    chk("R11", 32'(rm_ptr), 2);
    chk("R11", 32'(pending), 0);

    // R1 reset clears store-and-forward
    rst = 1'b1;
    tick();
    rst = 1'b0;
    #1;
    chk("R1", 32'(sf_mode), 0);
    chk("R1", 32'(ins_ptr), 0);
    peek(0);
    chk("R1", rd_ctrl, 32'h8100_0000);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule